// File: doc/BRIEF.md
# Half-Rate Three-Element Window Summer

This block computes running sums over three adjacent elements of a stored array, `sum[j] = b[j] + b[j+1] + b[j+2]`, when the read port can deliver at most two elements per clock. A run is started with a pulse on `start` and an output count on `run_len`. The block then drives the element indices it wants, one fetch per cycle. The fetches alternate between a pair (`b[j]`, `b[j+1]`) and a single element (`b[j+2]`). The memory returns the addressed data on `rd_d0` and `rd_d1` in the same cycle.

The pair goes into a partial adder. The single element follows one stage behind, and a delay register holds the partial sum until the two line up. Every other pipeline slot is therefore a bubble. A valid bit travels with the data, so a bubble never raises `out_valid`. After a fill of four edges, a result appears every second cycle, which is half the rate of a port three elements wide. The runs always index the array from element 0.

Top module: `pair_window_sum`

## Requirements
- R1: While `rst_n` is low, and after it is released, `busy`, `rd_pair`, `out_valid` and `out_sum` are 0.
- R2: A `start` pulse with `run_len` > 0, sampled while `busy` is 0, starts a run of `run_len` results, and `busy` is 1 for exactly 2·`run_len` cycles. A `start` with `run_len` = 0 does nothing, and `busy` stays 0.
- R3: In run cycle 2j (counting from 0), `rd_pair` is 1, `rd_idx0` = j and `rd_idx1` = j+1. In cycle 2j+1, `rd_pair` is 0 and `rd_idx0` = j+2. The data for an index is taken from `rd_d0` (and from `rd_d1` for the second index) in the same cycle.
- R4: The first `out_valid` of a run is high 4 clock edges after the edge that accepted `start`, and the next ones follow every 2 cycles. `out_valid` is never high in two consecutive cycles, and a run of N results gives exactly N pulses.
- R5: In the k-th pulse of a run (k from 0), `out_sum` = b[k]+b[k+1]+b[k+2], at the full 10-bit width, so the maximum value 765 does not overflow.
- R6: `out_sum` holds its last value in every cycle where `out_valid` is 0.
- R7: In a single-element fetch cycle (`rd_pair` = 0), `rd_d1` has no effect on any result.
- R8: A `start` that arrives while `busy` is 1 is ignored, and the run in progress goes on unchanged.
- R9: A new run may be accepted in the first cycle after `busy` falls. Its fetches begin while the results of the previous run are still draining, and both runs' results come out complete and in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin a run |
| run_len | input | IW | Number of results in the run |
| busy | output | 1 | A run is fetching operands |
| rd_pair | output | 1 | 1: pair fetch this cycle; 0: single fetch or idle |
| rd_idx0 | output | IW | First requested element index |
| rd_idx1 | output | IW | Second requested index (meaningful on pair fetches) |
| rd_d0 | input | EW | Element at `rd_idx0`, same cycle |
| rd_d1 | input | EW | Element at `rd_idx1`, same cycle |
| out_valid | output | 1 | `out_sum` carries a new result this cycle |
| out_sum | output | EW+2 | Window sum |

## Verification
Two things can fall in the same cycle. One is the start of a new run. The other is the tail of the previous run, which is still leaving the pipeline. The bench holds `start` high for many cycles in a row, so the block itself chooses the first free cycle: `start` pulses that arrive while busy must be ignored, and the next run must be accepted the moment `busy` falls, while the old results are still on the way. A cycle-by-cycle model keeps a queue of the expected result edges and sums for all runs in flight. It checks the fetch indices, `out_valid` and `out_sum` on every clock. In single-fetch cycles it drives junk on `rd_d1`.

// File: rtl/pair_window_sum.sv
module pair_window_sum #(
  parameter int EW = 8,
  parameter int IW = 8,
  localparam int SW = EW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [IW-1:0] run_len,
  output logic          busy,
  output logic          rd_pair,
  output logic [IW-1:0] rd_idx0,
  output logic [IW-1:0] rd_idx1,
  input  logic [EW-1:0] rd_d0,
  input  logic [EW-1:0] rd_d1,
  output logic          out_valid,
  output logic [SW-1:0] out_sum
);

  logic          running, phase;
  logic [IW-1:0] base, left;
  logic [EW-1:0] s1_a, s1_b;
  logic          s1_p, s2_p, s3_p;
  logic [SW-1:0] s2_sum, s3_sum;

  assign busy    = running;
  assign rd_pair = running & ~phase;
  assign rd_idx0 = phase ? base + IW'(2) : base;
  assign rd_idx1 = base + IW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      phase   <= 1'b0;
      base    <= '0;
      left    <= '0;
    end else if (!running) begin
      if (start && run_len != '0) begin
        running <= 1'b1;
        phase   <= 1'b0;
        base    <= '0;
        left    <= run_len;
      end
    end else if (!phase) begin
      phase <= 1'b1;
    end else begin
      phase <= 1'b0;
      base  <= base + IW'(1);
      left  <= left - IW'(1);
      if (left == IW'(1)) running <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_a      <= '0;
      s1_b      <= '0;
      s1_p      <= 1'b0;
      s2_sum    <= '0;
      s2_p      <= 1'b0;
      s3_sum    <= '0;
      s3_p      <= 1'b0;
      out_valid <= 1'b0;
      out_sum   <= '0;
    end else begin
      s1_a      <= rd_d0;
      s1_b      <= rd_pair ? rd_d1 : '0;
      s1_p      <= rd_pair;
      s2_sum    <= SW'(s1_a) + SW'(s1_b);
      s2_p      <= s1_p;
      s3_sum    <= s2_sum;
      s3_p      <= s2_p;
      out_valid <= s3_p;
      if (s3_p) out_sum <= s3_sum + s2_sum;
    end
  end

  AST_IDLE_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rd_pair);  // R2
  AST_PAIR_THEN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pair |=> busy && !rd_pair);  // R3
  AST_SINGLE_SAME_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pair |=> rd_idx0 == $past(rd_idx0) + IW'(2));  // R3
  AST_VALID_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);  // R4
  AST_SUM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_sum));  // R6

endmodule

// File: tb/tb_pair_window_sum.sv
module tb_pair_window_sum;
  logic       clk = 1'b0;
  logic       rst_n, start, busy, rd_pair, out_valid;
  logic [7:0] run_len, rd_idx0, rd_idx1, rd_d0, rd_d1;
  logic [9:0] out_sum;

  always #5 clk = ~clk;

  pair_window_sum dut (
    .clk(clk), .rst_n(rst_n), .start(start), .run_len(run_len),
    .busy(busy), .rd_pair(rd_pair), .rd_idx0(rd_idx0), .rd_idx1(rd_idx1),
    .rd_d0(rd_d0), .rd_d1(rd_d1), .out_valid(out_valid), .out_sum(out_sum)
  );

  int mem [64];
  int exp_e[$];
  int exp_s[$];
  int e = 0, e_start = -1000, n = 0;
  int tests = 0, fails = 0;
  int last_sum = 0;
  string tag = "R1";

  task automatic chk(string r, int act, int expv);
    tests++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s (%s) actual=%0d expected=%0d", r, tag, act, expv);
    end
  endtask

  task automatic cyc(input logic st, input int ln);
    int c;
    start   = st;
    run_len = 8'(ln);
    @(posedge clk);
    if (st && ln > 0 && (e - e_start) >= 2 * n) begin
      e_start = e + 1;
      n = ln;
      for (int j = 0; j < ln; j++) begin
        exp_e.push_back(e_start + 4 + 2 * j);
        exp_s.push_back(mem[j] + mem[j + 1] + mem[j + 2]);
      end
    end
    e++;
    @(negedge clk);
    start = 1'b0;
    c = e - e_start;
    if (c < 2 * n) begin
      chk("R2 busy", int'(busy), 1);
      chk("R3 rd_pair", int'(rd_pair), (c % 2 == 0) ? 1 : 0);
      if (c % 2 == 0) begin
        chk("R3 idx0 pair", int'(rd_idx0), c / 2);
        chk("R3 idx1 pair", int'(rd_idx1), c / 2 + 1);
      end else begin
        chk("R3 idx0 single", int'(rd_idx0), (c - 1) / 2 + 2);
      end
    end else begin
      chk("R2 busy idle", int'(busy), 0);
    end
    if (exp_e.size() > 0 && exp_e[0] == e) begin
      chk("R4 out_valid", int'(out_valid), 1);
      chk("R5 out_sum", int'(out_sum), exp_s[0]);
      last_sum = exp_s[0];
      void'(exp_e.pop_front());
      void'(exp_s.pop_front());
    end else begin
      chk("R4 no pulse", int'(out_valid), 0);
      chk("R6 hold", int'(out_sum), last_sum);
    end
    rd_d0 = 8'(mem[rd_idx0 & 8'd63]);
    rd_d1 = rd_pair ? 8'(mem[rd_idx1 & 8'd63]) : 8'hA5;  // R7 junk on single fetch
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int k = 0; k < 64; k++) mem[k] = (k >= 50) ? 255 : ((k * 53 + 7) & 255);
    rst_n = 1'b0; start = 1'b0; run_len = '0; rd_d0 = '0; rd_d1 = '0;
    repeat (3) @(negedge clk);
    tag = "R1 reset";
    chk("R1 busy", int'(busy), 0);
    chk("R1 rd_pair", int'(rd_pair), 0);
    chk("R1 out_valid", int'(out_valid), 0);
    chk("R1 out_sum", int'(out_sum), 0);
    rst_n = 1'b1;
    cyc(1'b0, 0);
    tag = "R2 short run";
    cyc(1'b1, 3);
    repeat (12) cyc(1'b0, 0);
    tag = "R2 zero length";
    cyc(1'b1, 0);
    repeat (6) cyc(1'b0, 0);
    tag = "R8 start while busy";
    cyc(1'b1, 5);
    repeat (4) cyc(1'b1, 2);
    repeat (10) cyc(1'b0, 0);
    tag = "R9 back-to-back runs";
    repeat (30) cyc(1'b1, 4);
    repeat (14) cyc(1'b0, 0);
    tag = "R5 R7 long run to max sum";
    cyc(1'b1, 60);
    repeat (130) cyc(1'b0, 0);
    chk("R4 all pulses seen", exp_e.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule